// File: doc/BRIEF.md
# Data Object Mailbox Register Block

This block is the device-side register set of a configuration-space mailbox that carries data objects between a host and a local responder. The host reaches it over a plain dword register bus at capability-relative byte offsets. It loads a request one dword at a time into a write buffer and then issues a go command. The block checks the request and streams it out to the responder. It collects the response into a read buffer and raises a ready flag. The host then pops the response one dword at a time.

The responder side uses two valid/ready streams. On the request stream the block holds `req_valid`, `req_data` and `req_last` steady until `req_ready` accepts the dword. The one exception is abort, which may withdraw `req_valid` at any time. On the response stream the responder holds its dword until `rsp_ready`. `rsp_ready` is low while a request is still being sent and while the read buffer is full. During an abort, `rsp_ready` stays high and every dword offered is dropped. An abort command resets the exchange: both buffers are emptied, the error and ready flags are cleared, and busy is held for a fixed number of cycles. Interrupt status and the `irq` output report ready and error events when interrupts are enabled.

Top module: `objx_mailbox`

## Requirements
- R1: Byte offset 0x04 reads the capability word: bit 0 is the interrupt-support parameter and bits 11:1 the interrupt message number. Offsets 0x10 and any unmapped offset read 0.
- R2: After reset, the status word (offset 0x0C) and the control word read 0, `irq` is 0, and neither stream is active. Status bits: 0 busy, 1 interrupt status, 2 error, 31 ready.
- R3: Writes to offset 0x10 append request dwords. A control write (offset 0x08) with bit 31 (go) set starts the exchange when all of the following hold: at least 2 dwords are buffered, bits 17:0 of the second dword equal the number of buffered dwords, and the block is neither busy nor holding a response. The dwords are then sent in order, `req_last` marks the final one, and busy reads 1 from the go until the response ends.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_data` hold.
- R5: A go with fewer than 2 dwords, a length mismatch or a write-buffer overflow sets error, discards the request and leaves busy at 0.
- R6: A write to offset 0x10 while busy sets error and the dword is dropped.
- R7: Response dwords are accepted only after the whole request has been sent. Acceptance of the dword marked `rsp_last` clears busy and sets ready.
- R8: While ready is set, reading offset 0x14 returns the current response dword without advancing. A write of any value advances to the next dword. Ready clears when the last dword is passed. Offset 0x14 reads 0 when ready is clear.
- R9: A control write with bit 0 (abort) set empties both buffers and clears error and ready. Busy then reads 1 for exactly ABORT_CYCLES cycles. Abort takes priority over a go in the same write.
- R10: With the interrupt enable (control bit 1) set, a rise of ready or of error sets interrupt status and drives `irq` high. Writing 1 to status bit 1 clears both. With the enable clear, neither is set.
- R11: A go while a response is still unread sets error and leaves the pending response readable.
- R12: The control word reads back the interrupt enable at bit 1; go and abort always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Capability-relative byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| req_valid | output | 1 | Request dword valid |
| req_ready | input | 1 | Responder accepts request dword |
| req_data | output | 32 | Request dword |
| req_last | output | 1 | Final dword of the request |
| rsp_valid | input | 1 | Response dword valid |
| rsp_ready | output | 1 | Block accepts response dword |
| rsp_data | input | 32 | Response dword |
| rsp_last | input | 1 | Final dword of the response |
| irq | output | 1 | Interrupt request (interrupt status) |

## Verification
A wrong sequencer state shows at the ports in the same cycle. `rsp_ready` rising while `req_valid` is still high, or busy staying set past the response end, is visible at once in the status word. A wrong buffer count shows one go later as a spurious or missing error bit, because the length check compares against it. A wrong read pointer shows on the very next read of offset 0x14. Abort faults appear as an abort busy window that differs from ABORT_CYCLES, or as stale dwords in the next request.

// File: rtl/objx_pkg.sv
package objx_pkg;
  localparam int DW    = 32;
  localparam int LEN_W = 18;

  localparam logic [7:0] OFS_CAP = 8'h04;
  localparam logic [7:0] OFS_CTL = 8'h08;
  localparam logic [7:0] OFS_STS = 8'h0C;
  localparam logic [7:0] OFS_WMB = 8'h10;
  localparam logic [7:0] OFS_RMB = 8'h14;

  localparam int CTL_ABORT = 0;
  localparam int CTL_IEN   = 1;
  localparam int CTL_GO    = 31;
  localparam int ST_INT    = 1;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SEND,
    SQ_WAIT,
    SQ_ABORT
  } sq_state_e;
endpackage

// File: rtl/objx_fifo.sv
module objx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/objx_seq.sv
module objx_seq
  import objx_pkg::*;
#(
  parameter int ABORT_CYCLES = 4,
  localparam int CNT_W = $clog2(ABORT_CYCLES + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      abort,
  input  logic      req_done,
  input  logic      rsp_done,
  output sq_state_e state
);
  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      hold_cnt <= '0;
    end else if (abort) begin
      state    <= SQ_ABORT;
      hold_cnt <= CNT_W'(ABORT_CYCLES - 1);
    end else begin
      unique case (state)
        SQ_IDLE:  if (start)    state <= SQ_SEND;
        SQ_SEND:  if (req_done) state <= SQ_WAIT;
        SQ_WAIT:  if (rsp_done) state <= SQ_IDLE;
        SQ_ABORT: begin
          if (hold_cnt == '0) state <= SQ_IDLE;
          else                hold_cnt <= hold_cnt - 1'b1;
        end
        default:  state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/objx_mailbox.sv
module objx_mailbox
  import objx_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          WBUF_DEPTH   = 16,
  parameter int          RBUF_DEPTH   = 16,
  parameter int          ABORT_CYCLES = 4,
  parameter logic        IRQ_SUPPORT  = 1'b1,
  parameter logic [10:0] IRQ_MSG      = 11'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [31:0]       req_data,
  output logic              req_last,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  input  logic              rsp_last,
  output logic              irq
);
  localparam int WCW = $clog2(WBUF_DEPTH + 1);
  localparam int RCW = $clog2(RBUF_DEPTH + 1);

  sq_state_e        state;
  logic             busy, rdy_q, err_q, ien_q, ints_q, wovf_q;
  logic [LEN_W-1:0] len_q;

  logic             w_ctl, w_sts, w_wmb, w_rmb;
  logic             abort_cmd, go_cmd, go_ok, go_bad, err_set;
  logic             req_fire, req_done, rsp_fire, rsp_done;

  logic [DW-1:0]    whead, rhead;
  logic [WCW-1:0]   wcnt;
  logic [RCW-1:0]   rcnt;
  logic             wempty, wfull, rempty, rfull;
  logic             wpush, wflush, rpush, rpop;

  // register decode
  assign w_ctl = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));
  assign w_sts = bus_wr && (bus_addr == ADDR_W'(OFS_STS));
  assign w_wmb = bus_wr && (bus_addr == ADDR_W'(OFS_WMB));
  assign w_rmb = bus_wr && (bus_addr == ADDR_W'(OFS_RMB));

  assign abort_cmd = w_ctl && bus_wdata[CTL_ABORT];
  assign go_cmd    = w_ctl && bus_wdata[CTL_GO] && !bus_wdata[CTL_ABORT];
  assign busy      = (state != SQ_IDLE);

  assign go_ok  = go_cmd && !busy && !rdy_q && !wovf_q &&
                  (wcnt >= WCW'(2)) && (len_q == LEN_W'(wcnt));
  assign go_bad = go_cmd && !busy && !go_ok;

  assign err_set = (w_wmb && (busy || wfull)) || go_bad;

  // request side
  assign wpush     = w_wmb && !busy && !wfull;
  assign wflush    = abort_cmd || go_bad;
  assign req_valid = (state == SQ_SEND) && !wempty;
  assign req_data  = whead;
  assign req_last  = (wcnt == WCW'(1));
  assign req_fire  = req_valid && req_ready;
  assign req_done  = req_fire && req_last;

  // response side
  assign rsp_ready = ((state == SQ_WAIT) && !rfull) || (state == SQ_ABORT);
  assign rsp_fire  = rsp_valid && rsp_ready && (state == SQ_WAIT);
  assign rsp_done  = rsp_fire && rsp_last;
  assign rpush     = rsp_fire;
  assign rpop      = w_rmb && rdy_q;

  objx_fifo #(.WIDTH(DW), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .flush(wflush), .push(wpush), .din(bus_wdata),
    .pop(req_fire), .dout(whead), .count(wcnt), .empty(wempty), .full(wfull)
  );

  objx_fifo #(.WIDTH(DW), .DEPTH(RBUF_DEPTH)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .flush(abort_cmd), .push(rpush), .din(rsp_data),
    .pop(rpop), .dout(rhead), .count(rcnt), .empty(rempty), .full(rfull)
  );

  objx_seq #(.ABORT_CYCLES(ABORT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go_ok), .abort(abort_cmd),
    .req_done(req_done), .rsp_done(rsp_done), .state(state)
  );

  // length field of the second request dword
  always_ff @(posedge clk) begin
    if (!rst_n)                          len_q <= '0;
    else if (wpush && wcnt == WCW'(1))   len_q <= bus_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          wovf_q <= 1'b0;
    else if (wflush || go_ok)            wovf_q <= 1'b0;
    else if (w_wmb && !busy && wfull)    wovf_q <= 1'b1;
  end

  // status flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (abort_cmd) begin
      err_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (err_set) err_q <= 1'b1;
      if (rsp_done)                          rdy_q <= 1'b1;
      else if (rpop && rcnt == RCW'(1))      rdy_q <= 1'b0;
    end
  end

  // interrupt enable and status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      ints_q <= 1'b0;
    end else begin
      if (w_ctl) ien_q <= bus_wdata[CTL_IEN] & IRQ_SUPPORT;
      if (ien_q && !abort_cmd && (rsp_done || (err_set && !err_q)))
        ints_q <= 1'b1;
      else if (w_sts && bus_wdata[ST_INT])
        ints_q <= 1'b0;
    end
  end

  assign irq = ints_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_CAP): bus_rdata = {20'b0, IRQ_MSG, IRQ_SUPPORT};
      ADDR_W'(OFS_CTL): bus_rdata = {30'b0, ien_q, 1'b0};
      ADDR_W'(OFS_STS): bus_rdata = {rdy_q, 28'b0, err_q, ints_q, busy};
      ADDR_W'(OFS_RMB): bus_rdata = rdy_q ? rhead : '0;
      default:          bus_rdata = '0;
    endcase
  end

  logic unused_ok;
  assign unused_ok = rempty;
endmodule

// File: rtl/objx_mailbox_chk.sv
module objx_mailbox_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_abort,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_data,
  input logic              rsp_ready,
  input logic              irq,
  input logic              busy,
  input logic              rdy,
  input logic              err
);
  logic abort_wr, wmb_wr, rmb_wr;
  assign abort_wr = bus_wr && (bus_addr == ADDR_W'(8'h08)) && wd_abort;
  assign wmb_wr   = bus_wr && (bus_addr == ADDR_W'(8'h10));
  assign rmb_wr   = bus_wr && (bus_addr == ADDR_W'(8'h14));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !abort_wr |=> req_valid && $stable(req_data));

  a_r6_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    wmb_wr && busy && !abort_wr |=> err);

  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> busy && !rdy && !err);

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rdy || err));

  a_r7_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready);

  a_r11_ready_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !req_valid);

  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && !rmb_wr && !abort_wr |=> rdy);
endmodule

bind objx_mailbox objx_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_abort(bus_wdata[0]), .req_valid(req_valid), .req_ready(req_ready),
  .req_data(req_data), .rsp_ready(rsp_ready), .irq(irq), .busy(busy),
  .rdy(rdy_q), .err(err_q)
);

// File: tb/test_objx_mailbox.sv
module test_objx_mailbox;
  localparam int ABORT_N = 4;
  localparam logic [7:0] A_CAP = 8'h04, A_CTL = 8'h08, A_STS = 8'h0C,
                         A_WMB = 8'h10, A_RMB = 8'h14;
  // rows: dwords written, length field, expect error, response dwords
  localparam int VEC [6][4] = '{'{2, 2, 0, 2}, '{5, 5, 0, 3}, '{4, 6, 1, 0},
                                '{3, 3, 0, 16}, '{1, 1, 1, 0}, '{16, 16, 0, 4}};

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic req_valid, req_ready = 0, req_last;
  logic [31:0] req_data;
  logic rsp_valid = 0, rsp_ready, rsp_last = 0;
  logic [31:0] rsp_data = 0;
  logic irq;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  objx_mailbox i_objx_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_data(req_data), .req_last(req_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_last(rsp_last), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    bus_read(a, d);
    chk(d, exp, tag);
  endtask

  function automatic logic [31:0] req_word(input int k, input int i, input int lenf);
    if (i == 0) return {8'h00, 8'(k + 1), 16'h0B00 + 16'(k)};
    if (i == 1) return 32'(lenf);
    return 32'hD000_0000 | (32'(k) << 8) | 32'(i);
  endfunction

  function automatic logic [31:0] rsp_word(input int k, input int i);
    return 32'hC500_0000 | (32'(k) << 8) | 32'(i);
  endfunction

  task automatic issue_req(input int k, input int n, input int lenf, input logic ien);
    for (int i = 0; i < n; i++) bus_write(A_WMB, req_word(k, i, lenf));
    bus_write(A_CTL, 32'h8000_0000 | (32'(ien) << 1));
  endtask

  task automatic collect_req(input int k, input int n, input int lenf);
    int got = 0, cyc = 0;
    logic stalled = 0;
    logic [31:0] held = 0;
    while (got < n && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (stalled) begin
        chk({31'b0, req_valid}, 32'd1, "R4 valid held");
        chk(req_data, held, "R4 data held");
      end
      req_ready = (cyc % 3 != 0);
      #1;
      if (req_valid && req_ready) begin
        chk(req_data, req_word(k, got, lenf), "R3 request dword");
        chk({31'b0, req_last}, 32'(got == n - 1), "R3 last flag");
        got++;
        stalled = 0;
      end else begin
        stalled = req_valid;
        held = req_data;
      end
    end
    @(negedge clk);
    req_ready = 0;
    chk(32'(got), 32'(n), "R3 request count");
  endtask

  task automatic send_rsp(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rsp_valid = 1; rsp_data = rsp_word(k, i); rsp_last = (i == n - 1);
      #1;
      while (!rsp_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    rsp_valid = 0; rsp_last = 0;
  endtask

  task automatic do_abort(input logic ien);
    logic [31:0] s;
    int cnt = 0;
    bus_write(A_CTL, 32'h1 | (32'(ien) << 1));
    bus_read(A_STS, s);
    while (s[0] && cnt < 50) begin
      cnt++;
      @(negedge clk);
      bus_read(A_STS, s);
    end
    chk(32'(cnt), 32'(ABORT_N), "R9 abort busy cycles");
    chk(s, 32'h0, "R9 status after abort");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state and fixed words
    rd_chk(A_STS, 32'h0, "R2 status reset");
    rd_chk(A_CTL, 32'h0, "R2 control reset");
    chk({29'b0, irq, req_valid, rsp_ready}, 32'h0, "R2 outputs reset");
    rd_chk(A_CAP, 32'h0000_000B, "R1 capability word");
    rd_chk(A_WMB, 32'h0, "R1 write mailbox reads 0");
    rd_chk(8'h18, 32'h0, "R1 unmapped offset");
    rd_chk(A_RMB, 32'h0, "R8 read mailbox empty");

    // table-driven exchanges
    for (int k = 0; k < 6; k++) begin
      issue_req(k, VEC[k][0], VEC[k][1], 1'b0);
      if (VEC[k][2] != 0) begin
        rd_chk(A_STS, 32'h4, "R5 bad go sets error");
        do_abort(1'b0);
      end else begin
        rd_chk(A_STS, 32'h1, "R3 busy after go");
        collect_req(k, VEC[k][0], VEC[k][1]);
        rd_chk(A_STS, 32'h1, "R7 busy until response");
        send_rsp(k, VEC[k][3]);
        rd_chk(A_STS, 32'h8000_0000, "R7 ready after last");
        for (int i = 0; i < VEC[k][3]; i++) begin
          rd_chk(A_RMB, rsp_word(k, i), "R8 response dword");
          if (i == 0) rd_chk(A_RMB, rsp_word(k, 0), "R8 read does not advance");
          bus_write(A_RMB, 32'hFFFF_FFFF);
        end
        rd_chk(A_STS, 32'h0, "R8 ready clears after last");
        rd_chk(A_RMB, 32'h0, "R8 reads 0 when not ready");
      end
    end

    // write while busy
    issue_req(6, 2, 2, 1'b0);
    bus_write(A_WMB, 32'h1234_5678);
    rd_chk(A_STS, 32'h5, "R6 write while busy sets error");
    chk({31'b0, req_valid}, 32'd1, "R4 request still offered");
    do_abort(1'b0);
    chk({31'b0, req_valid}, 32'd0, "R9 request withdrawn");

    // abort discards a partial request
    bus_write(A_WMB, req_word(7, 0, 2));
    do_abort(1'b0);
    issue_req(7, 2, 2, 1'b0);
    rd_chk(A_STS, 32'h1, "R9 partial request discarded");
    collect_req(7, 2, 2);
    send_rsp(7, 1);
    rd_chk(A_STS, 32'h8000_0000, "R7 single dword response");
    // go while response pending
    issue_req(8, 2, 2, 1'b0);
    rd_chk(A_STS, 32'h8000_0004, "R11 go with pending response");
    rd_chk(A_RMB, rsp_word(7, 0), "R11 pending response kept");
    do_abort(1'b0);

    // abort wins over go
    bus_write(A_WMB, req_word(9, 0, 2));
    bus_write(A_WMB, req_word(9, 1, 2));
    bus_write(A_CTL, 32'h8000_0001);
    chk({31'b0, req_valid}, 32'd0, "R9 abort beats go");
    repeat (ABORT_N + 1) @(negedge clk);
    bus_write(A_CTL, 32'h8000_0000);
    rd_chk(A_STS, 32'h4, "R9 buffer empty after abort");
    do_abort(1'b0);

    // interrupts
    bus_write(A_CTL, 32'h2);
    rd_chk(A_CTL, 32'h2, "R12 enable reads back");
    issue_req(10, 2, 2, 1'b1);
    rd_chk(A_CTL, 32'h2, "R12 go reads 0");
    collect_req(10, 2, 2);
    send_rsp(10, 1);
    rd_chk(A_STS, 32'h8000_0002, "R10 ready sets interrupt status");
    chk({31'b0, irq}, 32'd1, "R10 irq on ready");
    bus_write(A_STS, 32'h2);
    rd_chk(A_STS, 32'h8000_0000, "R10 status write clears");
    chk({31'b0, irq}, 32'd0, "R10 irq cleared");
    bus_write(A_RMB, 32'h0);
    bus_write(A_CTL, 32'h8000_0002);
    rd_chk(A_STS, 32'h6, "R10 error sets interrupt status");
    chk({31'b0, irq}, 32'd1, "R10 irq on error");
    bus_write(A_STS, 32'h2);
    chk({31'b0, irq}, 32'd0, "R10 irq cleared after error");
    do_abort(1'b1);
    bus_write(A_CTL, 32'h0);
    bus_write(A_CTL, 32'h8000_0000);
    rd_chk(A_STS, 32'h4, "R10 disabled: no interrupt status");
    chk({31'b0, irq}, 32'd0, "R10 disabled: irq low");
    do_abort(1'b0);
    bus_read(A_CTL, d);
    chk(d, 32'h0, "R12 enable cleared");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule